// File: doc/BRIEF.md
# Priority Interrupt Controller Core

This block collects up to eight interrupt request lines and raises one interrupt output toward a processor. A rising edge on a request line marks that line pending. A per-line mask keeps a pending line out of arbitration without discarding it. A fixed-priority arbiter picks the most urgent eligible line, with line 0 the most urgent. It compares that line against whatever the processor is already servicing.

When the processor acknowledges, the chosen line moves from pending to in-service and an 8-bit vector is presented. The vector is a fixed 5-bit base followed by the 3-bit line number. The processor later retires the most urgent in-service line with an end-of-interrupt command. A small register port (active-low select, write and read strobes, one address bit) loads the mask, issues commands and reads back the pending, in-service and mask registers.

Top module: `intc_core`

## Requirements
- R1: After reset the pending, in-service and mask registers are all zero, `irq_out` is 0, `vec_valid` is 0 and status reads at address 0 return the pending register.
- R2: A pending bit is set only by a 0-to-1 transition of its request line, seen at a clock edge. It stays set after the line falls. A line held high after being acknowledged does not set it again.
- R3: `irq_out` is 1 exactly when some unmasked pending line is more urgent than every in-service line. When nothing is in service, any unmasked pending line is enough.
- R4: Urgency is fixed: line 0 is the most urgent and line 7 the least urgent.
- R5: A mask bit of 1 removes that line from arbitration, but its pending bit is kept and is still readable. Masking a more urgent line never stops a less urgent line from being chosen.
- R6: When `ack` is sampled high while `irq_out` is 1, the chosen line's in-service bit is set and its pending bit is cleared at that edge. From that edge `vec_out` = {base[4:0], line[2:0]} and `vec_valid` is 1 for one cycle.
- R7: An in-service line blocks pending lines of equal or lower urgency from raising `irq_out`. A more urgent pending line still raises it.
- R8: A write at address 0 with data 8'h20 clears only the most urgent set in-service bit.
- R9: A write at address 0 with data 8'h0A selects the pending register for address-0 reads, and 8'h0B selects the in-service register. A read at address 1 returns the mask. `rdata` is 0 whenever no read is in progress.
- R10: While `cs_n` is 1, writes change neither the mask nor the in-service register, and reads return 0.
- R11: An `ack` while `irq_out` is 0 returns the vector for line 7 and changes neither the pending nor the in-service register.
- R12: Address-0 write data other than 8'h20, 8'h0A and 8'h0B changes nothing.
- R13: A write at address 1 loads the whole mask register from `wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 8 | Interrupt request lines, edge detected |
| irq_out | output | 1 | Interrupt to the processor |
| ack | input | 1 | Acknowledge, one cycle high per acknowledge |
| vec_out | output | 8 | Vector of the last acknowledge |
| vec_valid | output | 1 | One-cycle strobe: `vec_out` is fresh |
| cs_n | input | 1 | Register port select, active low |
| wr_n | input | 1 | Write strobe, active low, one cycle per write |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |

## Verification
The bench builds nested service and checks the equal-urgency case. A design that lets an in-service line block only lower lines would re-interrupt on the same line, and one that ignores in-service state would interrupt on lower lines. It masks line 0 while lines 0 and 1 are both pending. A design that stops arbitration at the first masked bit would never choose line 1, and one that clears masked pending bits would lose line 0's request. It acknowledges while the only pending line is blocked, expecting the line-7 vector with no state change. A design that services blocked lines would corrupt the in-service register. It retires one of two in-service lines, so a design that clears the wrong bit, or all bits, shows up in the in-service read-back.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam logic [7:0] CMD_EOI    = 8'h20;
   localparam logic [7:0] CMD_RD_REQ = 8'h0A;
   localparam logic [7:0] CMD_RD_ISR = 8'h0B;

   typedef enum logic {
      SEL_PEND = 1'b0,
      SEL_SERV = 1'b1
   } rd_sel_e;
endpackage

// File: rtl/intc_prio.sv
module intc_prio #(
   parameter int unsigned N  = 8,
   parameter int unsigned LW = 3
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [N-1:0]  onehot,
   output logic [LW-1:0] idx
);
   generate
      if (N != (1 << LW)) begin : g_bad_width
         $error("intc_prio: N must equal 2**LW");
      end
   endgenerate

   assign any    = |vec;
   assign onehot = vec & (~vec + 1'b1);

   genvar b, i;
   generate
      for (b = 0; b < LW; b++) begin : g_bit
         logic [N-1:0] sel;
         for (i = 0; i < N; i++) begin : g_line
            assign sel[i] = ((i >> b) & 1) == 1;
         end
         assign idx[b] = |(onehot & sel);
      end
   endgenerate
endmodule

// File: rtl/intc_req.sv
module intc_req #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend,
   output logic [N-1:0] rise
);
   logic [N-1:0] irq_q;

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_line
         assign rise[i] = irq[i] & ~irq_q[i];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q[i] <= 1'b0;
               pend[i]  <= 1'b0;
            end else begin
               irq_q[i] <= irq[i];
               pend[i]  <= (pend[i] & ~clr[i]) | rise[i];
            end
         end
      end
   endgenerate

   p_set_by_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~$past(pend) & ~$past(rise)) == '0));
endmodule

// File: rtl/intc_regport.sv
module intc_regport
   import intc_pkg::*;
#(
   parameter int unsigned N = 8,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          wr_n,
   input  logic          rd_n,
   input  logic          addr,
   input  logic [DW-1:0] wdata,
   input  logic [N-1:0]  pend,
   input  logic [N-1:0]  serv,
   output logic [N-1:0]  mask,
   output logic          eoi,
   output logic [DW-1:0] rdata
);
   generate
      if (DW < N) begin : g_bad_dw
         $error("intc_regport: data width narrower than line count");
      end
   endgenerate

   rd_sel_e sel;
   logic    wr_en, rd_en;

   assign wr_en = !cs_n && !wr_n;
   assign rd_en = !cs_n && !rd_n;
   assign eoi   = wr_en && !addr && (wdata == DW'(CMD_EOI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= '0;
         sel  <= SEL_PEND;
      end else if (wr_en) begin
         if (addr) begin
            mask <= wdata[N-1:0];
         end else if (wdata == DW'(CMD_RD_REQ)) begin
            sel <= SEL_PEND;
         end else if (wdata == DW'(CMD_RD_ISR)) begin
            sel <= SEL_SERV;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (addr)                  rdata = DW'(mask);
         else if (sel == SEL_SERV)  rdata = DW'(serv);
         else                       rdata = DW'(pend);
      end
   end

   p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (mask == $past(mask)));
   p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_n |-> (rdata == '0));
endmodule

// File: rtl/intc_core.sv
module intc_core #(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned VEC_BASE  = 17
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_req,
   output logic                 irq_out,
   input  logic                 ack,
   output logic [DATA_W-1:0]    vec_out,
   output logic                 vec_valid,
   input  logic                 cs_n,
   input  logic                 wr_n,
   input  logic                 rd_n,
   input  logic                 addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata
);
   localparam int unsigned LVL_W  = $clog2(NUM_LINES);
   localparam int unsigned BASE_W = DATA_W - LVL_W;
   localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(NUM_LINES - 1);

   generate
      if (NUM_LINES < 2 || NUM_LINES != (1 << LVL_W)) begin : g_bad_lines
         $error("intc_core: NUM_LINES must be a power of two, at least 2");
      end
      if (VEC_BASE >= (1 << BASE_W)) begin : g_bad_base
         $error("intc_core: VEC_BASE does not fit the vector");
      end
   endgenerate

   logic [NUM_LINES-1:0] pend, rise, mask, serv, cand, ack_clr;
   logic [NUM_LINES-1:0] cand_oh, serv_oh, serv_nxt;
   logic [LVL_W-1:0]     cand_idx, serv_idx;
   logic                 cand_any, serv_any, eoi, take;

   intc_req #(.N(NUM_LINES)) u_req (
      .clk(clk), .rst_n(rst_n), .irq(irq_req), .clr(ack_clr),
      .pend(pend), .rise(rise)
   );

   intc_regport #(.N(NUM_LINES), .DW(DATA_W)) u_port (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .addr(addr), .wdata(wdata), .pend(pend), .serv(serv),
      .mask(mask), .eoi(eoi), .rdata(rdata)
   );

   assign cand = pend & ~mask;

   intc_prio #(.N(NUM_LINES), .LW(LVL_W)) u_prio_cand (
      .vec(cand), .any(cand_any), .onehot(cand_oh), .idx(cand_idx)
   );
   intc_prio #(.N(NUM_LINES), .LW(LVL_W)) u_prio_serv (
      .vec(serv), .any(serv_any), .onehot(serv_oh), .idx(serv_idx)
   );

   assign irq_out = cand_any && (!serv_any || (cand_idx < serv_idx));
   assign take    = ack && irq_out;
   assign ack_clr = take ? cand_oh : '0;

   always_comb begin
      serv_nxt = serv;
      if (eoi)  serv_nxt = serv_nxt & ~serv_oh;
      if (take) serv_nxt = serv_nxt | cand_oh;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         serv      <= '0;
         vec_out   <= '0;
         vec_valid <= 1'b0;
      end else begin
         serv      <= serv_nxt;
         vec_valid <= ack;
         if (ack) begin
            vec_out <= {BASE_W'(VEC_BASE), (take ? cand_idx : LVL_LAST)};
         end
      end
   end

   p_irq_needs_cand_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> ((pend & ~mask) != '0));
   p_ack_sets_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_out && !eoi) |=> ((serv & ~$past(serv)) == $past(cand_oh)));
   p_spurious_still_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !irq_out && !eoi) |=> (serv == $past(serv)));
   p_eoi_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !ack && (serv != '0)) |=>
         ($countones(serv) + 1 == $countones($past(serv))));
endmodule

// File: tb/test_intc_core.sv
module test_intc_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_req = '0;
   logic       irq_out, ack = 1'b0, vec_valid;
   logic [7:0] vec_out, wdata = '0, rdata;
   logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, addr = 1'b0;
   int         checks = 0, errors = 0;
   localparam logic [4:0] BASE = 5'd17;

   always #5 clk = ~clk;

   intc_core i_intc_core (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_out(irq_out),
      .ack(ack), .vec_out(vec_out), .vec_valid(vec_valid),
      .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .addr(addr),
      .wdata(wdata), .rdata(rdata)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; irq_req = '0; ack = 1'b0;
      cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic wr(input logic sel_n, input logic a, input logic [7:0] d);
      cs_n = sel_n; wr_n = 1'b0; addr = a; wdata = d;
      tick();
      cs_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic rd(input logic sel_n, input logic a, output logic [7:0] d);
      cs_n = sel_n; rd_n = 1'b0; addr = a;
      #1 d = rdata;
      cs_n = 1'b1; rd_n = 1'b1;
      #1;
   endtask

   task automatic do_ack(input string req, input logic [2:0] lvl);
      ack = 1'b1;
      tick();
      ack = 1'b0;
      check({req, " vec_valid"}, {7'd0, vec_valid}, 8'd1);
      check({req, " vector"}, vec_out, {BASE, lvl});
   endtask

   task automatic t_reset();
      logic [7:0] d;
      do_reset();
      check("R1 irq_out", {7'd0, irq_out}, 8'd0);
      check("R1 vec_valid", {7'd0, vec_valid}, 8'd0);
      rd(1'b0, 1'b0, d); check("R1 pending", d, 8'h00);
      rd(1'b0, 1'b1, d); check("R1 mask", d, 8'h00);
      wr(1'b0, 1'b0, 8'h0B);
      rd(1'b0, 1'b0, d); check("R1 in-service", d, 8'h00);
      check("R9 idle rdata", rdata, 8'h00);
   endtask

   task automatic t_edge_nest();
      logic [7:0] d;
      do_reset();
      irq_req = 8'h20; tick();
      check("R3 irq_out raised", {7'd0, irq_out}, 8'd1);
      rd(1'b0, 1'b0, d); check("R2 pending set", d, 8'h20);
      irq_req = 8'h00; tick();
      rd(1'b0, 1'b0, d); check("R2 pending kept", d, 8'h20);
      do_ack("R6", 3'd5);
      check("R6 vec_valid pulse", {7'd0, vec_valid}, 8'd1);
      tick();
      check("R6 vec_valid drops", {7'd0, vec_valid}, 8'd0);
      rd(1'b0, 1'b0, d); check("R6 pending cleared", d, 8'h00);
      wr(1'b0, 1'b0, 8'h0B);
      rd(1'b0, 1'b0, d); check("R9 in-service read", d, 8'h20);
      irq_req = 8'hA0; tick();
      check("R7 equal and lower blocked", {7'd0, irq_out}, 8'd0);
      irq_req = 8'hA2; tick();
      check("R7 higher interrupts", {7'd0, irq_out}, 8'd1);
      wr(1'b0, 1'b0, 8'h0A);
      rd(1'b0, 1'b0, d); check("R9 pending read", d, 8'hA2);
   endtask

   task automatic t_held_level();
      logic [7:0] d;
      do_reset();
      irq_req = 8'h40; tick();
      do_ack("R6", 3'd6);
      tick(); tick();
      rd(1'b0, 1'b0, d); check("R2 held level no relatch", d, 8'h00);
   endtask

   task automatic t_priority();
      logic [7:0] d;
      do_reset();
      irq_req = 8'h48; tick();
      do_ack("R4", 3'd3);
      check("R7 lower blocked", {7'd0, irq_out}, 8'd0);
      do_ack("R11", 3'd7);
      rd(1'b0, 1'b0, d); check("R11 pending unchanged", d, 8'h40);
      wr(1'b0, 1'b0, 8'h0B);
      rd(1'b0, 1'b0, d); check("R11 in-service unchanged", d, 8'h08);
      wr(1'b0, 1'b0, 8'h20);
      rd(1'b0, 1'b0, d); check("R8 eoi clears", d, 8'h00);
      check("R3 irq after eoi", {7'd0, irq_out}, 8'd1);
      do_ack("R4", 3'd6);
   endtask

   task automatic t_mask();
      logic [7:0] d;
      do_reset();
      wr(1'b0, 1'b1, 8'h01);
      rd(1'b0, 1'b1, d); check("R13 mask load", d, 8'h01);
      irq_req = 8'h03; tick();
      check("R5 lower not blocked", {7'd0, irq_out}, 8'd1);
      do_ack("R5", 3'd1);
      rd(1'b0, 1'b0, d); check("R5 masked still pending", d, 8'h01);
      check("R5 masked no irq", {7'd0, irq_out}, 8'd0);
      wr(1'b0, 1'b1, 8'h00);
      check("R5 unmask raises irq", {7'd0, irq_out}, 8'd1);
   endtask

   task automatic t_eoi();
      logic [7:0] d;
      do_reset();
      irq_req = 8'h10; tick();
      do_ack("R6", 3'd4);
      irq_req = 8'h14; tick();
      check("R7 nest higher", {7'd0, irq_out}, 8'd1);
      do_ack("R6", 3'd2);
      wr(1'b0, 1'b0, 8'h0B);
      rd(1'b0, 1'b0, d); check("R6 two in service", d, 8'h14);
      wr(1'b0, 1'b0, 8'h20);
      rd(1'b0, 1'b0, d); check("R8 only most urgent cleared", d, 8'h10);
      wr(1'b0, 1'b0, 8'h20);
      rd(1'b0, 1'b0, d); check("R8 second eoi", d, 8'h00);
   endtask

   task automatic t_select();
      logic [7:0] d;
      do_reset();
      irq_req = 8'h01; tick();
      do_ack("R6", 3'd0);
      wr(1'b1, 1'b1, 8'hFF);
      rd(1'b0, 1'b1, d); check("R10 deselected mask write", d, 8'h00);
      wr(1'b1, 1'b0, 8'h20);
      wr(1'b0, 1'b0, 8'h0B);
      rd(1'b0, 1'b0, d); check("R10 deselected eoi", d, 8'h01);
      rd(1'b1, 1'b0, d); check("R10 deselected read", d, 8'h00);
      wr(1'b0, 1'b0, 8'h55);
      rd(1'b0, 1'b0, d); check("R12 unknown code", d, 8'h01);
      wr(1'b0, 1'b0, 8'h21);
      rd(1'b0, 1'b0, d); check("R12 near eoi code", d, 8'h01);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_edge_nest();
      t_held_level();
      t_priority();
      t_mask();
      t_eoi();
      t_select();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule